// File: doc/BRIEF.md
# DMA Read Prefetch FIFO

This block streams a contiguous region of memory into a local byte FIFO ahead of a consumer. A start command gives a base address and a byte count. The block then sends bounded read requests toward a DMA issuer, and each request occupies one slot of a small request pool. Data comes back on a completion channel tagged with the slot number. It is held in that slot's local storage until the slot reaches the head of the issue order. Only then is it written into the FIFO. A consumer pulls a chosen number of bytes per call and receives a success or failure flag.

Flow control uses credits. A request goes out only if the bytes already buffered, plus the bytes still owed by outstanding slots, plus the new request's bytes, fit in the FIFO. A stop command ends issuing at once. In-flight requests are not aborted, but they are marked cancelled, and their data is thrown away when they retire. Two single-cycle pulses report progress: one when the last request of a block is accepted, and one when the last outstanding request retires.

The issue side is controlled by a three-state machine:
- `ST_IDLE` means nothing is outstanding and no block is active.
- `ST_FILL` means the block still has bytes left to request.
- `ST_DRAIN` means the block has been fully requested or stopped, and slots may still be outstanding.

The transitions are:
- IDLE→FILL on an accepted start with a non-zero size.
- FILL→DRAIN when the final request is accepted or on stop.
- DRAIN→FILL on an accepted start with a non-zero size.
- DRAIN→IDLE when the slot count is zero.

Top module: `dma_prefetch_fifo`

## Requirements
- R1: An accepted start loads the next request address with `start_addr_i` and the block end with `start_addr_i + start_size_i`. A start is accepted only when the block is not in `ST_FILL` and `stop_i` is low, and it is ignored otherwise. The first request carries the start address.
- R2: Each request length is min(`MAX_REQ`, end − next address). It is never zero. Successive requests of one block have contiguous addresses.
- R3: A request is offered only while FIFO occupancy + outstanding request bytes + the new length ≤ `FIFO_BYTES`. Occupancy + outstanding bytes never exceed `FIFO_BYTES`.
- R4: At most `SLOTS` requests are outstanding. Slot ids are handed out in rotating order 0,1,…,`SLOTS`−1,0. A slot is reused only after it has retired.
- R5: Completions retire strictly in issue order, at most one per cycle, one edge after the head slot's completion is captured. A younger completion waits behind an unfinished older one and reaches the FIFO only after the older one does.
- R6: `stop_i` forces next address to the end address, so no further request is offered from the following cycle on. It marks every outstanding slot cancelled, including one retiring in the stop cycle. Cancelled data is discarded at retirement.
- R7: A get of N bytes (`get_i` high, `get_len_i` = N) is checked against current occupancy. One cycle later `get_done_o` pulses. `get_ok_o` is 1 with the N oldest bytes in `get_data_o` (byte i in bits 8i+7..8i) if N ≤ occupancy. Otherwise `get_ok_o` is 0 and the FIFO is unchanged.
- R8: `eob_o` pulses for one cycle after the edge at which the final request of a block is accepted. A stop does not raise it.
- R9: `idle_o` pulses for one cycle after the edge at which the last outstanding slot retires with no new request accepted in the same cycle.
- R10: After reset, no request is offered, the FIFO is empty, all slots are free, and `eob_o`, `idle_o` and `get_done_o` are low.
- R11: While `req_valid_o` is high and `req_ready_i` is low, the request stays offered with unchanged address and length until accepted or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new block |
| start_addr_i | input | AW | Block start address |
| start_size_i | input | AW | Block size in bytes |
| stop_i | input | 1 | End issuing and cancel outstanding data |
| req_valid_o | output | 1 | Read request offered |
| req_ready_i | input | 1 | Issuer accepts the request |
| req_addr_o | output | AW | Request byte address |
| req_len_o | output | clog2(MAX_REQ+1) | Request length in bytes |
| req_slot_o | output | SIDW | Slot tag of the request |
| cpl_valid_i | input | 1 | Completion data present |
| cpl_slot_i | input | SIDW | Slot tag of the completion |
| cpl_data_i | input | 8*MAX_REQ | Completion bytes, byte 0 at the request address |
| get_i | input | 1 | Consumer pull |
| get_len_i | input | clog2(MAX_GET+1) | Bytes to pull |
| get_done_o | output | 1 | Pull result valid |
| get_ok_o | output | 1 | Pull succeeded |
| get_data_o | output | 8*MAX_GET | Pulled bytes, oldest in byte 0 |
| eob_o | output | 1 | Final request of the block accepted |
| idle_o | output | 1 | Last outstanding request retired |

## Verification
Each result has a fixed delay after its stimulus:
- The first request is offered in the cycle after the edge that captures a start.
- A completion captured at one edge retires at the next edge, and the bytes become visible to a get from then on.
- A get is captured at one edge, and its flag and data are valid after that edge.
- `eob_o` and `idle_o` are high during the cycle after their triggering edge.

The bench drives inputs one time unit after a rising edge. It reads outputs and records accepted requests at the falling edge that follows the edge where each result is due. It waits at least one extra edge after a completion before it probes the FIFO through a get.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } fill_state_e;
endpackage

// File: rtl/dpf_byte_fifo.sv
module dpf_byte_fifo #(
    parameter int DEPTH  = 16,
    parameter int WR_MAX = 4,
    parameter int RD_MAX = 8,
    localparam int PW  = $clog2(DEPTH),
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int WLW = $clog2(WR_MAX + 1),
    localparam int RLW = $clog2(RD_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WLW-1:0]      wr_len,
    input  logic [8*WR_MAX-1:0] wr_data,
    input  logic                rd_en,
    input  logic [RLW-1:0]      rd_len,
    output logic [8*RD_MAX-1:0] peek,
    output logic [CW-1:0]       occ
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        for (int i = 0; i < WR_MAX; i++) begin
            if (wr_en && (i < int'(wr_len))) begin
                mem[wp + PW'(i)] <= wr_data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (wr_en) wp <= wp + PW'(wr_len);
            if (rd_en) rp <= rp + PW'(rd_len);
            occ <= occ + (wr_en ? CW'(wr_len) : '0) - (rd_en ? CW'(rd_len) : '0);
        end
    end

    always_comb begin
        for (int j = 0; j < RD_MAX; j++) begin
            peek[8*j +: 8] = mem[rp + PW'(j)];
        end
    end

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_len) <= int'(occ))); // R7
    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(occ) + int'(wr_len) <= DEPTH)); // R3
endmodule

// File: rtl/dpf_slot_ring.sv
module dpf_slot_ring #(
    parameter int SLOTS   = 3,
    parameter int MAX_REQ = 4,
    parameter int PEND_W  = 5,
    localparam int SIDW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int SCW  = $clog2(SLOTS + 1),
    localparam int RLW  = $clog2(MAX_REQ + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic [RLW-1:0]       alloc_len,
    input  logic                 cpl_valid,
    input  logic [SIDW-1:0]      cpl_slot,
    input  logic [8*MAX_REQ-1:0] cpl_data,
    input  logic                 cancel_all,
    output logic                 slot_free,
    output logic [SIDW-1:0]      alloc_id,
    output logic                 retire,
    output logic [RLW-1:0]       retire_len,
    output logic                 retire_cancel,
    output logic [8*MAX_REQ-1:0] retire_data,
    output logic [SCW-1:0]       count,
    output logic [PEND_W-1:0]    pend
);
    localparam logic [SIDW-1:0] LAST = SIDW'(SLOTS - 1);

    logic [SLOTS-1:0]     busy, done_q, canc;
    logic [RLW-1:0]       size_q [SLOTS];
    logic [8*MAX_REQ-1:0] data_q [SLOTS];
    logic [SIDW-1:0]      head, tail;

    assign slot_free     = (count < SCW'(SLOTS));
    assign alloc_id      = tail;
    assign retire        = (count != '0) && done_q[head];
    assign retire_len    = size_q[head];
    assign retire_cancel = canc[head];
    assign retire_data   = data_q[head];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= '0;
            done_q <= '0;
            canc   <= '0;
            head   <= '0;
            tail   <= '0;
            count  <= '0;
            pend   <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                size_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (alloc && (tail == SIDW'(i))) begin
                    busy[i]   <= 1'b1;
                    done_q[i] <= 1'b0;
                    canc[i]   <= 1'b0;
                    size_q[i] <= alloc_len;
                end else begin
                    if (retire && (head == SIDW'(i))) begin
                        busy[i]   <= 1'b0;
                        done_q[i] <= 1'b0;
                    end
                    if (cpl_valid && (cpl_slot == SIDW'(i))) begin
                        done_q[i] <= 1'b1;
                        data_q[i] <= cpl_data;
                    end
                    if (cancel_all && busy[i]) canc[i] <= 1'b1;
                end
            end
            if (alloc)  tail <= (tail == LAST) ? '0 : tail + 1'b1;
            if (retire) head <= (head == LAST) ? '0 : head + 1'b1;
            count <= count + SCW'(alloc) - SCW'(retire);
            pend  <= pend + (alloc ? PEND_W'(alloc_len) : '0)
                          - (retire ? PEND_W'(size_q[head]) : '0);
        end
    end

    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= SLOTS); // R4
    AST_CPL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (int'(cpl_slot) < SLOTS) && busy[cpl_slot] && !done_q[cpl_slot]); // R5
endmodule

// File: rtl/dma_prefetch_fifo.sv
module dma_prefetch_fifo
    import dpf_pkg::*;
#(
    parameter int AW         = 16,
    parameter int FIFO_BYTES = 16,
    parameter int MAX_REQ    = 4,
    parameter int SLOTS      = 3,
    parameter int MAX_GET    = 8,
    localparam int CNTW = $clog2(FIFO_BYTES + 1),
    localparam int RLW  = $clog2(MAX_REQ + 1),
    localparam int GLW  = $clog2(MAX_GET + 1),
    localparam int SIDW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int SCW  = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [AW-1:0]        start_addr_i,
    input  logic [AW-1:0]        start_size_i,
    input  logic                 stop_i,
    output logic                 req_valid_o,
    input  logic                 req_ready_i,
    output logic [AW-1:0]        req_addr_o,
    output logic [RLW-1:0]       req_len_o,
    output logic [SIDW-1:0]      req_slot_o,
    input  logic                 cpl_valid_i,
    input  logic [SIDW-1:0]      cpl_slot_i,
    input  logic [8*MAX_REQ-1:0] cpl_data_i,
    input  logic                 get_i,
    input  logic [GLW-1:0]       get_len_i,
    output logic                 get_done_o,
    output logic                 get_ok_o,
    output logic [8*MAX_GET-1:0] get_data_o,
    output logic                 eob_o,
    output logic                 idle_o
);
    fill_state_e state, state_nx;

    logic [AW-1:0]        next_addr, end_addr, remaining;
    logic [RLW-1:0]       req_size;
    logic [CNTW+1:0]      credit_sum;
    logic                 credit_ok, issue, last_issue, start_ok, get_fits, wr_en;
    logic                 slot_free, retire, retire_cancel;
    logic [SIDW-1:0]      alloc_id;
    logic [RLW-1:0]       retire_len;
    logic [8*MAX_REQ-1:0] retire_data;
    logic [SCW-1:0]       slot_count;
    logic [CNTW-1:0]      pend, occ;
    logic [8*MAX_GET-1:0] peek;

    assign remaining  = end_addr - next_addr;
    assign req_size   = (remaining >= AW'(MAX_REQ)) ? RLW'(MAX_REQ) : remaining[RLW-1:0];
    assign credit_sum = (CNTW+2)'(occ) + (CNTW+2)'(pend) + (CNTW+2)'(req_size);
    assign credit_ok  = credit_sum <= (CNTW+2)'(FIFO_BYTES);
    assign start_ok   = start_i && !stop_i && (state != ST_FILL);
    assign get_fits   = int'(get_len_i) <= int'(occ);
    assign wr_en      = retire && !(retire_cancel || stop_i);

    // Output process: request channel derived from state and credit
    always_comb begin
        req_valid_o = (state == ST_FILL) && (remaining != '0) && slot_free
                      && credit_ok && !stop_i;
        req_addr_o  = next_addr;
        req_len_o   = req_size;
        req_slot_o  = alloc_id;
        issue       = req_valid_o && req_ready_i;
        last_issue  = issue && (remaining == AW'(req_size));
    end

    // Next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_ok && start_size_i != '0) state_nx = ST_FILL;
            ST_FILL:  if (stop_i || last_issue)          state_nx = ST_DRAIN;
            ST_DRAIN: begin
                if (start_ok && start_size_i != '0) state_nx = ST_FILL;
                else if (slot_count == '0)          state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register and block-address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            next_addr  <= '0;
            end_addr   <= '0;
            eob_o      <= 1'b0;
            idle_o     <= 1'b0;
            get_done_o <= 1'b0;
            get_ok_o   <= 1'b0;
            get_data_o <= '0;
        end else begin
            state <= state_nx;
            if (start_ok) begin
                next_addr <= start_addr_i;
                end_addr  <= start_addr_i + start_size_i;
            end else if (stop_i) begin
                next_addr <= end_addr;
            end else if (issue) begin
                next_addr <= next_addr + AW'(req_size);
            end
            eob_o      <= last_issue;
            idle_o     <= retire && (slot_count == SCW'(1)) && !issue;
            get_done_o <= get_i;
            get_ok_o   <= get_i && get_fits;
            if (get_i) get_data_o <= peek;
        end
    end

    dpf_slot_ring #(
        .SLOTS(SLOTS), .MAX_REQ(MAX_REQ), .PEND_W(CNTW)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .alloc(issue), .alloc_len(req_size),
        .cpl_valid(cpl_valid_i), .cpl_slot(cpl_slot_i), .cpl_data(cpl_data_i),
        .cancel_all(stop_i),
        .slot_free(slot_free), .alloc_id(alloc_id),
        .retire(retire), .retire_len(retire_len), .retire_cancel(retire_cancel),
        .retire_data(retire_data), .count(slot_count), .pend(pend)
    );

    dpf_byte_fifo #(
        .DEPTH(FIFO_BYTES), .WR_MAX(MAX_REQ), .RD_MAX(MAX_GET)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_len(retire_len), .wr_data(retire_data),
        .rd_en(get_i && get_fits), .rd_len(get_len_i),
        .peek(peek), .occ(occ)
    );

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) + int'(pend) <= FIFO_BYTES); // R3
    AST_REQ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_len_o != '0) && (int'(req_len_o) <= MAX_REQ)); // R2
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !req_valid_o); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !stop_i) |=>
            (stop_i || (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)))); // R11
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (slot_count == '0)); // R9
    AST_EOB_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        eob_o |-> (next_addr == end_addr) && (state != ST_FILL)); // R8
endmodule

// File: tb/tb_dma_prefetch_fifo.sv
module tb_dma_prefetch_fifo;
    localparam int AW = 16, FB = 16, MR = 4, NS = 3, MG = 8;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, stop_i = 0, req_ready_i = 1, cpl_valid_i = 0, get_i = 0;
    logic [AW-1:0] start_addr_i = '0, start_size_i = '0;
    logic req_valid_o, get_done_o, get_ok_o, eob_o, idle_o;
    logic [AW-1:0] req_addr_o;
    logic [2:0] req_len_o;
    logic [1:0] req_slot_o, cpl_slot_i = '0;
    logic [8*MR-1:0] cpl_data_i = '0;
    logic [3:0] get_len_i = '0;
    logic [8*MG-1:0] get_data_o;

    always #5 clk = ~clk;

    dma_prefetch_fifo #(.AW(AW), .FIFO_BYTES(FB), .MAX_REQ(MR), .SLOTS(NS), .MAX_GET(MG)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .start_size_i(start_size_i), .stop_i(stop_i), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_len_o(req_len_o),
        .req_slot_o(req_slot_o), .cpl_valid_i(cpl_valid_i), .cpl_slot_i(cpl_slot_i),
        .cpl_data_i(cpl_data_i), .get_i(get_i), .get_len_i(get_len_i),
        .get_done_o(get_done_o), .get_ok_o(get_ok_o), .get_data_o(get_data_o),
        .eob_o(eob_o), .idle_o(idle_o));

    int n_chk = 0, n_fail = 0;
    int rec_n = 0, eob_cnt = 0, idle_cnt = 0;
    int rec_addr [64];
    int rec_len  [64];
    int rec_slot [64];
    int slot_addr [4];

    function automatic logic [7:0] mb(input int a);
        return 8'(a ^ (a >> 5) ^ 8'hA5);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid_o && req_ready_i && rec_n < 64) begin
                rec_addr[rec_n] = int'(req_addr_o);
                rec_len[rec_n]  = int'(req_len_o);
                rec_slot[rec_n] = int'(req_slot_o);
                slot_addr[req_slot_o] = int'(req_addr_o);
                rec_n++;
            end
            if (eob_o)  eob_cnt++;
            if (idle_o) idle_cnt++;
        end
    end

    task automatic chk(input bit c, input string req, input longint act, input longint exp);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_start(input int addr, input int size);
        @(posedge clk); #1;
        start_i = 1; start_addr_i = AW'(addr); start_size_i = AW'(size);
        @(posedge clk); #1;
        start_i = 0;
    endtask

    task automatic do_stop();
        @(posedge clk); #1; stop_i = 1;
        @(posedge clk); #1; stop_i = 0;
    endtask

    task automatic complete(input int s);
        @(posedge clk); #1;
        cpl_valid_i = 1; cpl_slot_i = 2'(s);
        for (int i = 0; i < MR; i++) cpl_data_i[8*i +: 8] = mb(slot_addr[s] + i);
        @(posedge clk); #1;
        cpl_valid_i = 0;
    endtask

    task automatic do_get(input int len, input bit exp_ok, input int base, input string req);
        logic [8*MG-1:0] mask, expd;
        @(posedge clk); #1; get_i = 1; get_len_i = 4'(len);
        @(posedge clk); #1; get_i = 0;
        @(negedge clk);
        chk(get_done_o == 1'b1, req, get_done_o, 1);
        chk(get_ok_o == exp_ok, req, get_ok_o, exp_ok);
        if (exp_ok && len > 0) begin
            mask = '0; expd = '0;
            for (int i = 0; i < len; i++) begin
                mask[8*i +: 8] = 8'hFF;
                expd[8*i +: 8] = mb(base + i);
            end
            chk((get_data_o & mask) == expd, req, get_data_o & mask, expd);
        end
    endtask

    task automatic chk_rec(input int k, input int addr, input int len, input string req);
        chk(rec_addr[k] == addr, req, rec_addr[k], addr);
        chk(rec_len[k] == len, req, rec_len[k], len);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_valid_o == 1'b0, "R10 no request", req_valid_o, 0);
        chk({eob_o, idle_o, get_done_o} == 3'b000, "R10 pulses low", {eob_o, idle_o, get_done_o}, 0);
        do_get(1, 1'b0, 0, "R10 empty get fails");
    endtask

    task automatic t_basic();
        int b = rec_n, e = eob_cnt, d = idle_cnt;
        do_start(16'h100, 10);
        cycles(6);
        chk(rec_n - b == 3, "R2 three requests", rec_n - b, 3);
        chk_rec(b,     16'h100, 4, "R1 first request at start");
        chk_rec(b + 1, 16'h104, 4, "R2 contiguous full request");
        chk_rec(b + 2, 16'h108, 2, "R2 tail request shortened");
        chk(rec_slot[b] == 0 && rec_slot[b+1] == 1 && rec_slot[b+2] == 2,
            "R4 rotating slot ids", rec_slot[b+2], 2);
        chk(eob_cnt - e == 1, "R8 one end-of-block pulse", eob_cnt - e, 1);
        for (int k = 0; k < 3; k++) complete(rec_slot[b + k]);
        cycles(3);
        chk(idle_cnt - d == 1, "R9 idle pulse after last retire", idle_cnt - d, 1);
        do_get(4, 1'b1, 16'h100, "R7 get 4 succeeds");
        do_get(8, 1'b0, 0,       "R7 get 8 fails with 6 buffered");
        do_get(6, 1'b1, 16'h104, "R7 failed get left buffer intact");
    endtask

    task automatic t_credit();
        int b = rec_n;
        do_start(16'h200, 20);
        cycles(6);
        chk(rec_n - b == 3, "R4 slot pool limits outstanding", rec_n - b, 3);
        complete(rec_slot[b]);
        cycles(3);
        chk(rec_n - b == 4, "R4 retired slot reused", rec_n - b, 4);
        chk(rec_slot[b + 3] == rec_slot[b], "R4 reused slot id", rec_slot[b + 3], rec_slot[b]);
        for (int k = 1; k < 4; k++) complete(rec_slot[b + k]);
        cycles(4);
        chk(rec_n - b == 4, "R3 full FIFO blocks issue", rec_n - b, 4);
        @(negedge clk);
        chk(req_valid_o == 1'b0, "R3 request withheld", req_valid_o, 0);
        do_get(4, 1'b1, 16'h200, "R3 get frees credit");
        cycles(3);
        chk(rec_n - b == 5, "R3 issue after credit returns", rec_n - b, 5);
        chk_rec(b + 4, 16'h210, 4, "R3 resumed request");
        complete(rec_slot[b + 4]);
        cycles(2);
        do_get(8, 1'b1, 16'h204, "R3 data after credit 1");
        do_get(8, 1'b1, 16'h20C, "R3 data after credit 2");
    endtask

    task automatic t_order();
        int b = rec_n;
        do_start(16'h300, 8);
        cycles(5);
        chk(rec_n - b == 2, "R5 two requests", rec_n - b, 2);
        complete(rec_slot[b + 1]);
        cycles(3);
        do_get(1, 1'b0, 0, "R5 younger completion held back");
        complete(rec_slot[b]);
        cycles(3);
        do_get(8, 1'b1, 16'h300, "R5 in-order data");
    endtask

    task automatic t_stop();
        int b, d, e;
        @(posedge clk); #1; req_ready_i = 0;
        b = rec_n; e = eob_cnt;
        do_start(16'h400, 40);
        cycles(3);
        @(negedge clk);
        chk(rec_n == b && req_valid_o == 1'b1, "R11 request offered under backpressure", rec_n - b, 0);
        chk(req_addr_o == 16'h400 && req_len_o == 3'd4, "R11 request held", req_addr_o, 16'h400);
        @(posedge clk); #1; req_ready_i = 1;
        cycles(5);
        chk(rec_n - b == 3, "R11 held request accepted", rec_n - b, 3);
        d = idle_cnt;
        do_stop();
        cycles(2);
        @(negedge clk);
        chk(req_valid_o == 1'b0, "R6 no request after stop", req_valid_o, 0);
        for (int k = 0; k < 3; k++) complete(rec_slot[b + k]);
        cycles(3);
        chk(rec_n - b == 3, "R6 nothing issued after stop", rec_n - b, 3);
        chk(idle_cnt - d == 1, "R6 idle after cancelled retire", idle_cnt - d, 1);
        chk(eob_cnt == e, "R8 stop raises no end-of-block", eob_cnt - e, 0);
        do_get(1, 1'b0, 0, "R6 cancelled data discarded");
        b = rec_n;
        do_start(16'h500, 4);
        cycles(4);
        chk(rec_n - b == 1, "R1 start accepted after stop", rec_n - b, 1);
        chk_rec(b, 16'h500, 4, "R1 restart address");
        complete(rec_slot[b]);
        cycles(2);
        do_get(4, 1'b1, 16'h500, "R1 restart data");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        #1 rst_n = 1;
        t_reset();
        t_basic();
        t_credit();
        t_order();
        t_stop();
        cycles(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule